// File: doc/BRIEF.md
# Stopwatch with Best-Time Memory

This block is a four-digit decimal stopwatch that keeps the shortest completed run. It is split into a datapath and a control unit. The datapath holds a packed-BCD elapsed-time counter, a best-time register with parallel load, a less-than comparator between the two, and a selector that picks which of the two values drives the display word. The control unit is a state machine that reads four synchronous buttons (clear, start, stop, show-best) and a count-enable pulse. It drives the counter clear and count enable, the best-time load and preset, and the display select.

A run begins with start, which zeroes the elapsed time. Each cycle in which the tick pulse is high advances the time by one decimal step, and stop freezes it. In the cycle after stop, the frozen time is compared with the stored best. If it is strictly smaller, it replaces the best. While the watch is idle or stopped, holding show-best presents the stored best instead of the elapsed time. The clear button returns the block to its power-up condition: elapsed time zero and best time all nines. Segment decoding is left to the display logic outside the block.

Top module: `stopwatch_best`

## Requirements
- R1: After reset, disp reads 16'h0000. Pressing show-best while idle makes disp read 16'h9999, the preset best time.
- R2: Start, sampled while idle, stopped or showing the best, zeroes the elapsed time and enters the running state. While running, each clock edge that samples tick high advances the elapsed time by one in packed BCD, with the least significant digit in bits 3:0. An edge that samples tick low leaves the time unchanged. disp shows the elapsed time throughout.
- R3: Every digit counts 0 to 9 and wraps to 0 with a carry into the next digit. The value 9999 advances to 0000.
- R4: The edge that samples stop still counts a tick sampled with it. After that edge the elapsed time stays frozen whatever tick does, and disp keeps showing it.
- R5: One cycle after stop, the best time is loaded from the elapsed time only if the elapsed time is strictly less than the best time. The best time therefore always equals the minimum of 9999 and all completed run times.
- R6: Holding show-best with start low, while idle or stopped, makes disp show the best time from the next cycle on. Releasing it returns disp to the frozen elapsed time.
- R7: Start sampled while running has no effect: the elapsed time is neither cleared nor interrupted.
- R8: Clear, sampled in any state, returns the block to its power-up condition within two cycles: disp shows 0000 and the best time is 9999.
- R9: When start and show-best are sampled together while stopped, start wins. A new run begins and disp shows the zeroed elapsed time, not the best.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_btn | input | 1 | Synchronous return to power-up condition |
| start_btn | input | 1 | Begin a new run |
| stop_btn | input | 1 | End the current run |
| show_btn | input | 1 | Display the best time while held (idle or stopped) |
| tick | input | 1 | Count enable pulse for the elapsed time |
| disp | output | 16 | Packed-BCD display value: best time or elapsed time |

## Verification
The assertions assume that every button and the tick pulse are synchronous to clk and stable around the rising edge. They also assume that clear overrides all other buttons in the cycle it is sampled. The bench meets this by changing every input only on the falling edge, so each input is seen by exactly one rising edge per value. The best-time monotonicity check assumes that only the preset path can raise the stored value. The stimulus therefore exercises raising only through clear and reset. Run lengths are chosen so that equal, larger, smaller, zero and wrapped times all reach the comparator.

// File: rtl/sw_pkg.sv
package sw_pkg;

    typedef enum logic [2:0] {
        ST_INIT  = 3'd0,
        ST_READY = 3'd1,
        ST_RUN   = 3'd2,
        ST_CMP   = 3'd3,
        ST_HOLD  = 3'd4,
        ST_SHOW  = 3'd5
    } sw_state_e;

    typedef struct packed {
        logic clr_tm;
        logic en_tm;
        logic ld_best;
        logic init_best;
        logic sel_best;
    } sw_ctl_t;

endpackage

// File: rtl/sw_bcd_counter.sv
module sw_bcd_counter #(
    parameter int DIGITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              en_i,
    output logic [4*DIGITS-1:0] cnt_o
);
    localparam int W = 4 * DIGITS;

    logic [W-1:0]    cnt_q;
    logic [W-1:0]    cnt_d;
    logic [DIGITS:0] carry;

    assign carry[0] = en_i;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [3:0] cur;
        logic       at_nine;
        assign cur            = cnt_q[4*g +: 4];
        assign at_nine        = (cur == 4'd9);
        assign carry[g+1]     = carry[g] & at_nine;
        assign cnt_d[4*g +: 4] = clr_i    ? 4'd0 :
                                 carry[g] ? (at_nine ? 4'd0 : cur + 4'd1) :
                                            cur;

        // R3: each stored digit stays in the decimal range
        a_r3_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q[4*g +: 4] <= 4'd9);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R4: without enable or clear the elapsed time is frozen
    a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/sw_best_reg.sv
module sw_best_reg #(
    parameter int DIGITS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                init_i,
    input  logic                ld_i,
    input  logic [4*DIGITS-1:0] d_i,
    output logic [4*DIGITS-1:0] q_o,
    output logic                altb_o
);
    localparam int W = 4 * DIGITS;
    localparam logic [W-1:0] ALL_NINE = {DIGITS{4'h9}};

    logic [W-1:0] best_q;
    logic [W-1:0] best_d;

    always_comb begin
        best_d = best_q;
        if (init_i)    best_d = ALL_NINE;
        else if (ld_i) best_d = d_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) best_q <= ALL_NINE;
        else        best_q <= best_d;
    end

    // packed BCD keeps decimal order, so a binary compare is exact
    assign altb_o = (d_i < best_q);
    assign q_o    = best_q;

    // R5: the best time never grows except through the preset
    a_r5_best_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i) |=> (best_q <= $past(best_q)));

endmodule

// File: rtl/sw_ctrl.sv
module sw_ctrl
    import sw_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clear_i,
    input  logic    start_i,
    input  logic    stop_i,
    input  logic    show_i,
    input  logic    tick_i,
    input  logic    altb_i,
    output sw_ctl_t ctl_o
);
    sw_state_e state_q;
    sw_state_e state_d;

    always_comb begin
        state_d = state_q;
        ctl_o   = '0;
        case (state_q)
            ST_INIT: begin
                ctl_o.clr_tm    = 1'b1;
                ctl_o.init_best = 1'b1;
                state_d         = ST_READY;
            end
            ST_READY, ST_HOLD: begin
                if (start_i) begin
                    ctl_o.clr_tm = 1'b1;
                    state_d      = ST_RUN;
                end else if (show_i) begin
                    state_d = ST_SHOW;
                end
            end
            ST_SHOW: begin
                ctl_o.sel_best = 1'b1;
                if (start_i) begin
                    ctl_o.clr_tm = 1'b1;
                    state_d      = ST_RUN;
                end else if (!show_i) begin
                    state_d = ST_HOLD;
                end
            end
            ST_RUN: begin
                ctl_o.en_tm = tick_i;
                if (stop_i) state_d = ST_CMP;
            end
            ST_CMP: begin
                ctl_o.ld_best = altb_i;
                state_d       = ST_HOLD;
            end
            default: state_d = ST_INIT;
        endcase
        if (clear_i) state_d = ST_INIT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    // R5: a stop while running leads to the compare cycle
    a_r5_cmp_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && stop_i && !clear_i) |=> (state_q == ST_CMP));

    // R8: clear always returns to the preset state
    a_r8_clear_to_init: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (state_q == ST_INIT));

    // R9: start from a waiting state begins a run, even with show held
    a_r9_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_READY || state_q == ST_HOLD || state_q == ST_SHOW)
         && start_i && !clear_i) |=> (state_q == ST_RUN));

    // R7: start while running does not leave the running state
    a_r7_run_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !stop_i && !clear_i) |=> (state_q == ST_RUN));

endmodule

// File: rtl/stopwatch_best.sv
module stopwatch_best
    import sw_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_btn,
    input  logic                start_btn,
    input  logic                stop_btn,
    input  logic                show_btn,
    input  logic                tick,
    output logic [4*DIGITS-1:0] disp
);
    localparam int W = 4 * DIGITS;

    sw_ctl_t      ctl;
    logic [W-1:0] tm_val;
    logic [W-1:0] best_val;
    logic         tm_lt_best;

    sw_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_btn),
        .start_i (start_btn),
        .stop_i  (stop_btn),
        .show_i  (show_btn),
        .tick_i  (tick),
        .altb_i  (tm_lt_best),
        .ctl_o   (ctl)
    );

    sw_bcd_counter #(.DIGITS(DIGITS)) u_time (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (ctl.clr_tm),
        .en_i  (ctl.en_tm),
        .cnt_o (tm_val)
    );

    sw_best_reg #(.DIGITS(DIGITS)) u_best (
        .clk    (clk),
        .rst_n  (rst_n),
        .init_i (ctl.init_best),
        .ld_i   (ctl.ld_best),
        .d_i    (tm_val),
        .q_o    (best_val),
        .altb_o (tm_lt_best)
    );

    assign disp = ctl.sel_best ? best_val : tm_val;

    // R6: while the best is selected the display carries it
    a_r6_show_best: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.sel_best |-> (disp == best_val));

endmodule

// File: tb/stopwatch_best_tb.sv
`timescale 1ns/1ps
module stopwatch_best_tb;
    localparam int D = 4;
    localparam int W = 4 * D;
    localparam int MODV = 10000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear_btn = 1'b0, start_btn = 1'b0, stop_btn = 1'b0, show_btn = 1'b0, tick = 1'b0;
    logic [W-1:0] disp;

    int checks = 0;
    int fails = 0;
    int best = 9999;

    always #2 clk = ~clk;

    stopwatch_best #(.DIGITS(D)) u_dut (
        .clk(clk), .rst_n(rst_n), .clear_btn(clear_btn), .start_btn(start_btn),
        .stop_btn(stop_btn), .show_btn(show_btn), .tick(tick), .disp(disp)
    );

    function automatic logic [W-1:0] to_bcd(int v);
        logic [W-1:0] r = '0;
        int x = v;
        for (int i = 0; i < D; i++) begin
            r[4*i +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    // one run: n cycles in RUN, tick every 'per' cycles (0 = never), start pulse at 'sa'
    task automatic run_once(int n, int per, int sa);
        int cnt = 0;
        start_btn = 1'b1;
        cyc();
        start_btn = 1'b0;
        chk("R2 start clears", disp, '0);
        for (int k = 0; k < n; k++) begin
            tick      = (per != 0) && (k % per == 0);
            stop_btn  = (k == n - 1);
            start_btn = (k == sa);
            cyc();
            if (tick) cnt++;
            chk("R2 R3 R7 count", disp, to_bcd(cnt % MODV));
        end
        stop_btn = 1'b0; start_btn = 1'b0; tick = 1'b1;
        cyc();
        if ((cnt % MODV) < best) best = cnt % MODV;
        for (int j = 0; j < 3; j++) begin
            cyc();
            chk("R4 frozen", disp, to_bcd(cnt % MODV));
        end
        tick = 1'b0;
        show_btn = 1'b1;
        cyc();
        chk("R5 R6 best shown", disp, to_bcd(best));
        cyc();
        chk("R6 held", disp, to_bcd(best));
        show_btn = 1'b0;
        cyc();
        chk("R6 release", disp, to_bcd(cnt % MODV));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        chk("R1 reset disp", disp, '0);
        cyc();
        show_btn = 1'b1;
        cyc();
        chk("R1 preset best", disp, 16'h9999);
        show_btn = 1'b0;
        cyc();
        chk("R1 idle disp", disp, '0);

        run_once(20, 1, -1);      // 20
        run_once(50, 3, 10);      // 17, start ignored mid-run
        run_once(30, 2, -1);      // 15
        run_once(40, 2, -1);      // 20 larger, no update
        run_once(15, 1, -1);      // 15 equal, no update
        run_once(120, 1, 60);     // carry into tens and hundreds
        run_once(MODV + 3, 1, -1);// wraps to 0003
        run_once(4, 0, -1);       // zero time

        // R9: start and show together from stopped
        start_btn = 1'b1; show_btn = 1'b1; tick = 1'b0;
        cyc();
        start_btn = 1'b0; show_btn = 1'b0; tick = 1'b1;
        chk("R9 start wins", disp, '0);
        cyc();
        chk("R9 running", disp, to_bcd(1));

        // R8: clear mid-run
        tick = 1'b0; clear_btn = 1'b1;
        cyc();
        clear_btn = 1'b0;
        cyc();
        chk("R8 time cleared", disp, '0);
        show_btn = 1'b1;
        cyc();
        chk("R8 best preset", disp, 16'h9999);
        show_btn = 1'b0;
        best = 9999;
        cyc();
        run_once(7, 1, -1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule